// File: doc/BRIEF.md
# Menu-Driven SPI Flash Cycle Engine

This block is a host-side SPI flash controller driven by a small register bus. Software never hands the block a raw command byte. It fills a menu of eight permitted command bytes, gives each entry a two-bit kind (read or write, with or without a 24-bit address), and loads two prefix bytes. A cycle is launched by a control write that names a menu slot. Optionally, a prefix byte goes out first in a chip-select frame of its own, before the main frame. The main frame carries the command byte, the address when the kind needs one, and an optional payload of 1 to 64 bytes held in a word-addressed buffer.

The command menu, the kinds and the prefixes can be frozen by a sticky lock bit. After that, only a reset makes them writable again. Status flags report a running cycle, completion and a rejected launch. Software clears the completion and rejection flags by writing ones to them.

Top module: `menu_spi_host`

## Requirements
- R1: After reset the status word reads 0, chip select is high, SCK is low and all menu, kind, prefix and lock registers read 0.
- R2: Register word map: 0 control, 1 status, 2 lock, 3 address, 4 prefix, 5 kinds, 6 menu low, 7 menu high. Menu slot n is byte n%4 of menu low (n<4) or menu high (n>=4). Slot n's kind is in kinds bits 2n+1:2n. Prefix A is bits 7:0 and prefix B is bits 15:8. Every one of these reads back as written while unlocked.
- R3: Control bit 8 set sends prefix A, or prefix B when bit 9 is also set, as a one-byte frame. Chip select then stays high for at least two SCK periods before the main frame begins.
- R4: Writing 1 to lock bit 0 makes the prefix, kinds and menu registers ignore writes. Writing 0 to the lock does not clear it; only reset does.
- R5: A control write with bit 0 set sends the menu byte of slot bits 6:4. For kinds 2 (read, addressed) and 3 (write, addressed), this is followed by address bits 23:16, 15:8 and 7:0. Kinds 0 and 1 send no address. Address bits 31:24 are never sent.
- R6: For kinds 1 and 3 with control bit 12 set, payload byte k is taken from bits 8*(k%4)+7:8*(k%4) of buffer word k/4. Count is field 21:16 plus one.
- R7: For kinds 0 and 2 with bit 12 set, the byte received on MISO in payload position k is stored at that buffer position, while MOSI sends 0x00. Buffer bytes at or beyond the count are left unchanged.
- R8: With bit 12 clear, the frame ends after the command byte (and address), and the buffer is not touched.
- R9: Status bit 0 (busy) is set from the accepted launch until bit 1 (done) is raised. Writing 1 to bits 1 or 2 clears them, and writing 0 leaves them alone.
- R10: A launch while busy sets status bit 2 (error). The running cycle continues and completes unchanged, and no extra frame is sent.
- R11: A launch whose count exceeds the buffer size sets the error bit, sets no busy flag and produces no SPI activity.
- R12: SPI mode 0: SCK idles low, each bit is driven MSB first and held across the rising edge where MISO is sampled, and each SCK phase lasts HALF_CLKS clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address; top bit selects the data buffer |
| bus_wen | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench sweeps every menu slot through all four kinds with payload sizes from one byte to the full buffer, and compares each captured frame byte for byte. A design that ignored the kind would send or omit the address wrongly, and one with swapped byte lanes would scramble the payload order. Reads check that only the addressed buffer bytes change, which would catch an overrun past the count. A launch during a running cycle and an oversized count must both raise the error flag without disturbing the wire. A lock that can be undone, or a prefix frame whose chip-select gap is too short, is caught from the register readback and from the timing of the frames.

// File: rtl/msh_pkg.sv
`timescale 1ns/1ps
package msh_pkg;
   localparam logic [2:0] RS_CTRL = 3'd0;
   localparam logic [2:0] RS_STAT = 3'd1;
   localparam logic [2:0] RS_LOCK = 3'd2;
   localparam logic [2:0] RS_ADDR = 3'd3;
   localparam logic [2:0] RS_PFX  = 3'd4;
   localparam logic [2:0] RS_KIND = 3'd5;
   localparam logic [2:0] RS_MLO  = 3'd6;
   localparam logic [2:0] RS_MHI  = 3'd7;

   // control word fields
   localparam int CB_GO   = 0;
   localparam int CB_SLOT = 4;
   localparam int CB_PRE  = 8;
   localparam int CB_PSEL = 9;
   localparam int CB_DATA = 12;
   localparam int CB_CNT  = 16;

   typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_GAP, ST_MAIN} eng_state_t;

   // kind bit 1: address phase, kind bit 0: payload goes out on MOSI
   function automatic logic kind_addr(input logic [1:0] k);
      return k[1];
   endfunction
   function automatic logic kind_out(input logic [1:0] k);
      return k[0];
   endfunction
endpackage

// File: rtl/msh_cfg_regs.sv
`timescale 1ns/1ps
module msh_cfg_regs
   import msh_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_i,
   input  logic [2:0]  sel_i,
   input  logic [31:0] wdata_i,
   output logic [63:0] menu_o,
   output logic [15:0] kinds_o,
   output logic [15:0] pfx_o,
   output logic        locked_o
);
   logic [63:0] menu_q;
   logic [15:0] kinds_q, pfx_q;
   logic        lock_q;
   logic        open_wr;

   assign open_wr = wr_i && !lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         menu_q  <= '0;
         kinds_q <= '0;
         pfx_q   <= '0;
         lock_q  <= 1'b0;
      end else begin
         if (wr_i && sel_i == RS_LOCK && wdata_i[0]) lock_q <= 1'b1;
         if (open_wr) begin
            case (sel_i)
               RS_PFX:  pfx_q          <= wdata_i[15:0];
               RS_KIND: kinds_q        <= wdata_i[15:0];
               RS_MLO:  menu_q[31:0]   <= wdata_i;
               RS_MHI:  menu_q[63:32]  <= wdata_i;
               default: ;
            endcase
         end
      end
   end

   assign menu_o   = menu_q;
   assign kinds_o  = kinds_q;
   assign pfx_o    = pfx_q;
   assign locked_o = lock_q;

   a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
   a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> ($stable(menu_q) && $stable(kinds_q) && $stable(pfx_q)));
endmodule

// File: rtl/msh_buffer.sv
`timescale 1ns/1ps
module msh_buffer #(
   parameter int BYTES = 64,
   localparam int WORDS = BYTES / 4,
   localparam int WI_W  = $clog2(WORDS),
   localparam int IDX_W = $clog2(BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we_i,
   input  logic [WI_W-1:0]  bus_widx_i,
   input  logic [31:0]      bus_wdata_i,
   input  logic [WI_W-1:0]  bus_ridx_i,
   output logic [31:0]      bus_rdata_o,
   input  logic [IDX_W-1:0] eng_ridx_i,
   output logic [7:0]       eng_rdata_o,
   input  logic             eng_we_i,
   input  logic [IDX_W-1:0] eng_widx_i,
   input  logic [7:0]       eng_wdata_i
);
   logic [WORDS*32-1:0] flat;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam logic [WI_W-1:0] MY = WI_W'(w);
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) word_q <= '0;
         else if (eng_we_i && eng_widx_i[IDX_W-1:2] == MY)
            word_q[{eng_widx_i[1:0], 3'b000} +: 8] <= eng_wdata_i;
         else if (bus_we_i && bus_widx_i == MY)
            word_q <= bus_wdata_i;
      end
      assign flat[w*32 +: 32] = word_q;
   end

   assign bus_rdata_o = flat[{bus_ridx_i, 5'b00000} +: 32];
   assign eng_rdata_o = flat[{eng_ridx_i, 3'b000} +: 8];
endmodule

// File: rtl/msh_engine.sv
`timescale 1ns/1ps
module msh_engine
   import msh_pkg::*;
#(
   parameter int HALF_CLKS = 2,
   parameter int BYTES     = 64,
   localparam int IDX_W    = $clog2(BYTES),
   localparam int DIV_W    = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1,
   localparam int GAP_CLKS = 4 * HALF_CLKS,
   localparam int GAP_W    = $clog2(GAP_CLKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [7:0]       opc_i,
   input  logic [7:0]       pfx_i,
   input  logic             use_pre_i,
   input  logic [1:0]       kind_i,
   input  logic             data_i,
   input  logic [6:0]       cnt_i,
   input  logic [23:0]      addr_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [IDX_W-1:0] rd_idx_o,
   input  logic [7:0]       rd_data_i,
   output logic             wr_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [7:0]       wr_data_o,
   output logic             sck_o,
   output logic             cs_n_o,
   output logic             mosi_o,
   input  logic             miso_i
);
   if (HALF_CLKS < 1) begin : g_bad_half
      $error("HALF_CLKS must be at least 1");
   end

   eng_state_t       state_q;
   logic [DIV_W-1:0] div_q;
   logic [GAP_W-1:0] gap_q;
   logic             sck_q, cs_n_q, done_q, pre_q, data_q;
   logic [7:0]       sh_q, rx_q, byte_q, last_q, opc_q, nxt, hdr, nb_idx;
   logic [2:0]       bit_q;
   logic [1:0]       kind_q;
   logic [6:0]       cnt_q;
   logic [23:0]      addr_q;
   logic             tick, byte_end;

   function automatic logic [7:0] main_last(input logic [1:0] k, input logic d,
                                            input logic [6:0] n);
      return (kind_addr(k) ? 8'd3 : 8'd0) + (d ? {1'b0, n} : 8'd0);
   endfunction

   assign tick     = (div_q == DIV_W'(HALF_CLKS - 1));
   assign byte_end = tick && sck_q && (bit_q == 3'd7);
   assign hdr      = kind_addr(kind_q) ? 8'd4 : 8'd1;
   assign nb_idx   = byte_q + 8'd1;
   assign rd_idx_o = IDX_W'(nb_idx - hdr);

   always_comb begin
      if (kind_addr(kind_q) && nb_idx == 8'd1)      nxt = addr_q[23:16];
      else if (kind_addr(kind_q) && nb_idx == 8'd2) nxt = addr_q[15:8];
      else if (kind_addr(kind_q) && nb_idx == 8'd3) nxt = addr_q[7:0];
      else if (kind_out(kind_q))                    nxt = rd_data_i;
      else                                          nxt = 8'h00;
   end

   assign wr_o      = (state_q == ST_MAIN) && byte_end && data_q &&
                      !kind_out(kind_q) && (byte_q >= hdr);
   assign wr_idx_o  = IDX_W'(byte_q - hdr);
   assign wr_data_o = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         div_q <= '0; gap_q <= '0;
         sck_q <= 1'b0; cs_n_q <= 1'b1; done_q <= 1'b0;
         pre_q <= 1'b0; data_q <= 1'b0;
         sh_q <= '0; rx_q <= '0; byte_q <= '0; last_q <= '0; opc_q <= '0;
         bit_q <= '0; kind_q <= '0; cnt_q <= '0; addr_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               opc_q <= opc_i; pre_q <= use_pre_i; kind_q <= kind_i;
               data_q <= data_i; cnt_q <= cnt_i; addr_q <= addr_i;
               div_q <= '0; sck_q <= 1'b0; bit_q <= '0; byte_q <= '0;
               cs_n_q <= 1'b0;
               if (use_pre_i) begin
                  state_q <= ST_PRE; sh_q <= pfx_i; last_q <= 8'd0;
               end else begin
                  state_q <= ST_MAIN; sh_q <= opc_i;
                  last_q <= main_last(kind_i, data_i, cnt_i);
               end
            end
            ST_PRE, ST_MAIN: begin
               if (tick) begin
                  div_q <= '0;
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                     rx_q  <= {rx_q[6:0], miso_i};
                  end else begin
                     sck_q <= 1'b0;
                     if (bit_q == 3'd7) begin
                        bit_q <= '0;
                        if (byte_q == last_q) begin
                           cs_n_q <= 1'b1;
                           if (state_q == ST_PRE) begin
                              state_q <= ST_GAP; gap_q <= '0;
                           end else begin
                              state_q <= ST_IDLE; done_q <= 1'b1;
                           end
                        end else begin
                           byte_q <= nb_idx;
                           sh_q   <= nxt;
                        end
                     end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                     end
                  end
               end else begin
                  div_q <= div_q + DIV_W'(1);
               end
            end
            ST_GAP: begin
               if (gap_q == GAP_W'(GAP_CLKS - 1)) begin
                  state_q <= ST_MAIN; cs_n_q <= 1'b0; sh_q <= opc_q;
                  byte_q <= '0; bit_q <= '0; div_q <= '0;
                  last_q <= main_last(kind_q, data_q, cnt_q);
               end else begin
                  gap_q <= gap_q + GAP_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;
   assign sck_o  = sck_q;
   assign cs_n_o = cs_n_q;
   assign mosi_o = cs_n_q ? 1'b0 : sh_q[7];

   // cycles with chip select high, saturating; observed when the main frame opens
   logic [GAP_W:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_cnt <= '0;
      else if (!cs_n_q) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + (GAP_W+1)'(1);
   end

   a_r3_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n_q) && state_q == ST_MAIN && pre_q) |-> hi_cnt >= (GAP_W+1)'(GAP_CLKS));
   a_r12_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |-> !sck_q);
endmodule

// File: rtl/menu_spi_host.sv
`timescale 1ns/1ps
module menu_spi_host
   import msh_pkg::*;
#(
   parameter int BUF_BYTES = 64,
   parameter int HALF_CLKS = 2,
   parameter int ADDR_W    = 6,
   localparam int WORDS    = BUF_BYTES / 4,
   localparam int WI_W     = $clog2(WORDS),
   localparam int IDX_W    = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   if (BUF_BYTES < 8 || BUF_BYTES > 64 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two from 8 to 64");
   end
   if (ADDR_W < WI_W + 1 || ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too small for the buffer window");
   end

   logic [63:0] menu;
   logic [15:0] kinds, pfx;
   logic        locked;
   logic        is_reg, is_data, reg_wr, go, over, bad, start;
   logic [2:0]  sel, slot;
   logic [6:0]  cnt;
   logic [31:0] addr_q, buf_word;
   logic        run_q, done_q, err_q;
   logic        eng_busy, eng_done, eng_wr;
   logic [IDX_W-1:0] eng_ridx, eng_widx;
   logic [7:0]  eng_rdata, eng_wdata;

   assign sel     = bus_addr[2:0];
   assign is_reg  = (bus_addr[ADDR_W-1:3] == '0);
   assign is_data = bus_addr[ADDR_W-1];
   assign reg_wr  = bus_wen && is_reg;
   assign go      = reg_wr && sel == RS_CTRL && bus_wdata[CB_GO];
   assign slot    = bus_wdata[CB_SLOT +: 3];
   assign cnt     = {1'b0, bus_wdata[CB_CNT +: 6]} + 7'd1;
   assign over    = bus_wdata[CB_DATA] && (cnt > 7'(BUF_BYTES));
   assign bad     = run_q || over;
   assign start   = go && !bad;

   msh_cfg_regs u_cfg (
      .clk, .rst_n, .wr_i(reg_wr), .sel_i(sel), .wdata_i(bus_wdata),
      .menu_o(menu), .kinds_o(kinds), .pfx_o(pfx), .locked_o(locked)
   );

   msh_buffer #(.BYTES(BUF_BYTES)) u_buf (
      .clk, .rst_n,
      .bus_we_i(bus_wen && is_data), .bus_widx_i(bus_addr[WI_W-1:0]),
      .bus_wdata_i(bus_wdata), .bus_ridx_i(bus_addr[WI_W-1:0]),
      .bus_rdata_o(buf_word),
      .eng_ridx_i(eng_ridx), .eng_rdata_o(eng_rdata),
      .eng_we_i(eng_wr), .eng_widx_i(eng_widx), .eng_wdata_i(eng_wdata)
   );

   msh_engine #(.HALF_CLKS(HALF_CLKS), .BYTES(BUF_BYTES)) u_eng (
      .clk, .rst_n, .start_i(start),
      .opc_i(menu[{slot, 3'b000} +: 8]),
      .pfx_i(bus_wdata[CB_PSEL] ? pfx[15:8] : pfx[7:0]),
      .use_pre_i(bus_wdata[CB_PRE]),
      .kind_i(kinds[{slot, 1'b0} +: 2]),
      .data_i(bus_wdata[CB_DATA]), .cnt_i(cnt), .addr_i(addr_q[23:0]),
      .busy_o(eng_busy), .done_o(eng_done),
      .rd_idx_o(eng_ridx), .rd_data_i(eng_rdata),
      .wr_o(eng_wr), .wr_idx_o(eng_widx), .wr_data_o(eng_wdata),
      .sck_o(spi_sck), .cs_n_o(spi_cs_n), .mosi_o(spi_mosi), .miso_i(spi_miso)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0; run_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      end else begin
         if (reg_wr && sel == RS_ADDR) addr_q <= bus_wdata;
         if (start) run_q <= 1'b1;
         else if (eng_done) run_q <= 1'b0;
         if (eng_done) done_q <= 1'b1;
         else if (reg_wr && sel == RS_STAT && bus_wdata[1]) done_q <= 1'b0;
         if (go && bad) err_q <= 1'b1;
         else if (reg_wr && sel == RS_STAT && bus_wdata[2]) err_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (is_data) bus_rdata = buf_word;
      else if (is_reg) begin
         case (sel)
            RS_STAT: bus_rdata = {29'b0, err_q, done_q, run_q};
            RS_LOCK: bus_rdata = {31'b0, locked};
            RS_ADDR: bus_rdata = addr_q;
            RS_PFX:  bus_rdata = {16'b0, pfx};
            RS_KIND: bus_rdata = {16'b0, kinds};
            RS_MLO:  bus_rdata = menu[31:0];
            RS_MHI:  bus_rdata = menu[63:32];
            default: bus_rdata = '0;
         endcase
      end
   end

   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !eng_busy);
   a_r9_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> run_q);
   a_r11_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (go && over) |=> (err_q && !eng_busy));
endmodule

// File: tb/test_menu_spi_host.sv
`timescale 1ns/1ps
module test_menu_spi_host;
   localparam int BUFB = 16;
   localparam int HALF = 2;
   localparam int DBASE = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic spi_sck, spi_cs_n, spi_mosi;
   logic spi_miso = 1'b0;

   int nchk = 0, nfail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   menu_spi_host #(.BUF_BYTES(BUFB), .HALF_CLKS(HALF), .ADDR_W(6)) i_menu_spi_host (
      .clk, .rst_n, .bus_addr, .bus_wen, .bus_wdata, .bus_rdata,
      .spi_sck, .spi_cs_n, .spi_mosi, .spi_miso
   );

   // ---- SPI observer and responder ----
   logic [7:0] fr_byte [0:7][0:31];
   int         fr_len [0:7];
   realtime    fr_start [0:7];
   realtime    fr_end [0:7];
   int nfr = 0, bitc = 0;
   logic [7:0] cur = '0;
   realtime t_rise = 0, hi_min = 1e9, hi_max = 0;

   function automatic logic [7:0] rsp_byte(input int j);
      return 8'((60 + 23 * j) & 255);
   endfunction

   always @(posedge spi_sck or posedge spi_cs_n) begin
      if (spi_cs_n) begin
         fr_len[nfr % 8] = bitc / 8;
         fr_end[nfr % 8] = $realtime;
         nfr = nfr + 1;
         bitc = 0;
      end else begin
         t_rise = $realtime;
         cur = {cur[6:0], spi_mosi};
         bitc = bitc + 1;
         if (bitc % 8 == 0 && bitc / 8 <= 32) fr_byte[nfr % 8][bitc / 8 - 1] = cur;
      end
   end

   always @(negedge spi_cs_n or negedge spi_sck) begin
      if (!spi_cs_n) begin
         if (!spi_sck && bitc == 0) fr_start[nfr % 8] = $realtime;
         if (bitc > 0) begin
            if ($realtime - t_rise < hi_min) hi_min = $realtime - t_rise;
            if ($realtime - t_rise > hi_max) hi_max = $realtime - t_rise;
         end
         spi_miso = rsp_byte(bitc / 8)[7 - (bitc % 8)];
      end
   end

   // ---- helpers ----
   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 6'(a); bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 6'(a);
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] s;
      for (int i = 0; i < 4000; i++) begin
         rd(1, s);
         if (!s[0]) return;
      end
      chk(1'b0, req, s, 32'h0);
   endtask

   function automatic logic [7:0] opc(input int n);
      return 8'(8'h81 + n * 8'h13);
   endfunction
   function automatic logic [7:0] pat(input int k, input int n);
      return 8'((k * 9 + n * 31 + 1) & 255);
   endfunction
   function automatic logic [31:0] ctrl(input int slot, input bit pre, input bit psel,
                                        input bit dat, input int cnt);
      return 32'd1 | (32'(slot) << 4) | (32'(pre) << 8) | (32'(psel) << 9) |
             (32'(dat) << 12) | (32'((cnt - 1) & 63) << 16);
   endfunction

   task automatic fill_buf(input int n);
      for (int w = 0; w < BUFB / 4; w++)
         wr(DBASE + w, {pat(4*w+3, n), pat(4*w+2, n), pat(4*w+1, n), pat(4*w, n)});
   endtask

   // expected main-frame byte j (kind = slot % 4)
   function automatic logic [7:0] exp_byte(input int n, input logic [23:0] a,
                                           input int j);
      int kind = n % 4;
      int hdr = (kind >= 2) ? 4 : 1;
      if (j == 0) return opc(n);
      if (kind >= 2 && j == 1) return a[23:16];
      if (kind >= 2 && j == 2) return a[15:8];
      if (kind >= 2 && j == 3) return a[7:0];
      if (kind % 2 == 1) return pat(j - hdr, n);
      return 8'h00;
   endfunction

   task automatic check_main(input string req, input int fi, input int n,
                             input logic [23:0] a, input int cnt, input bit dat);
      int kind = n % 4;
      int exp_len = 1 + ((kind >= 2) ? 3 : 0) + (dat ? cnt : 0);
      int bad = 0;
      logic [7:0] fb;
      chk(fr_len[fi % 8] == exp_len, req, 32'(fr_len[fi % 8]), 32'(exp_len));
      for (int j = 0; j < exp_len && j < 32; j++) begin
         fb = fr_byte[fi % 8][j];
         if (fb !== exp_byte(n, a, j)) begin
            if (bad == 0) chk(1'b0, req, {24'b0, fb}, {24'b0, exp_byte(n, a, j)});
            bad++;
         end
      end
      if (bad == 0) chk(1'b1, req, 0, 0);
   endtask

   task automatic check_buf(input string req, input int n, input int hdr,
                            input int cnt, input bit changed);
      logic [31:0] wd;
      logic [7:0] e, g;
      int bad = 0;
      for (int k = 0; k < BUFB; k++) begin
         if (k % 4 == 0) rd(DBASE + k / 4, wd);
         g = wd[8*(k%4) +: 8];
         e = (changed && k < cnt) ? rsp_byte(hdr + k) : pat(k, n);
         if (g !== e && bad == 0) begin
            chk(1'b0, req, {24'b0, g}, {24'b0, e});
            bad++;
         end
      end
      if (bad == 0) chk(1'b1, req, 0, 0);
   endtask

   initial begin
      #(150000 * 5);
      if (!finished) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [23:0] a;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(1, d); chk(d == 0, "R1 status", d, 0);
      chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins", {30'b0, spi_cs_n, spi_sck}, 32'h2);
      rd(6, d); chk(d == 0, "R1 menu", d, 0);
      rd(2, d); chk(d == 0, "R1 lock", d, 0);

      // R2 programming and readback
      wr(6, {opc(3), opc(2), opc(1), opc(0)});
      wr(7, {opc(7), opc(6), opc(5), opc(4)});
      wr(5, 32'h0000E4E4);
      wr(4, 32'h00005006);
      rd(6, d); chk(d == {opc(3), opc(2), opc(1), opc(0)}, "R2 menu low", d, {opc(3), opc(2), opc(1), opc(0)});
      rd(7, d); chk(d == {opc(7), opc(6), opc(5), opc(4)}, "R2 menu high", d, {opc(7), opc(6), opc(5), opc(4)});
      rd(5, d); chk(d == 32'hE4E4, "R2 kinds", d, 32'hE4E4);
      rd(4, d); chk(d == 32'h5006, "R2 prefix", d, 32'h5006);

      // R5 R6 R7 sweep over every slot, all four kinds
      for (int n = 0; n < 8; n++) begin
         int cnt = (n * 5) % 16 + 1;
         fill_buf(n);
         a = 24'(24'h123456 + n * 24'h010203);
         wr(3, {8'hC5, a});
         base = nfr;
         wr(0, ctrl(n, 0, 0, 1, cnt));
         wait_idle("R9 busy clears");
         chk(nfr == base + 1, "R5 one frame", 32'(nfr - base), 1);
         check_main((n % 4 == 1 || n % 4 == 3) ? "R6 write frame" : "R5 R7 read frame",
                    base, n, a, cnt, 1'b1);
         if (n % 2 == 0)
            check_buf("R7 read store", n, (n % 4 >= 2) ? 4 : 1, cnt, 1'b1);
         rd(1, d); chk(d == 32'h2, "R9 done set", d, 32'h2);
         wr(1, 32'h0);
         rd(1, d); chk(d == 32'h2, "R9 write 0 keeps", d, 32'h2);
         wr(1, 32'h2);
         rd(1, d); chk(d == 32'h0, "R9 w1c", d, 32'h0);
      end

      // R3 prefix frames, both prefixes, with gap
      for (int ps = 0; ps < 2; ps++) begin
         fill_buf(3);
         a = 24'hABCDEF;
         wr(3, {8'h00, a});
         base = nfr;
         wr(0, ctrl(3, 1, ps[0], 1, 2));
         wait_idle("R3 finish");
         chk(nfr == base + 2, "R3 two frames", 32'(nfr - base), 2);
         chk(fr_len[base % 8] == 1 && fr_byte[base % 8][0] == (ps ? 8'h50 : 8'h06),
             "R3 prefix byte", {24'b0, fr_byte[base % 8][0]}, ps ? 32'h50 : 32'h06);
         chk(fr_start[(base + 1) % 8] - fr_end[base % 8] >= 4 * HALF * 5 - 0.01,
             "R3 cs gap", 32'(int'(fr_start[(base + 1) % 8] - fr_end[base % 8])), 32'(4 * HALF * 5));
         check_main("R3 main after prefix", base + 1, 3, a, 2, 1'b1);
         wr(1, 32'h6);
      end

      // R8 no payload phase: addressed read leaves buffer untouched
      fill_buf(2);
      a = 24'h00FF01;
      wr(3, {8'h00, a});
      base = nfr;
      wr(0, ctrl(2, 0, 0, 0, 5));
      wait_idle("R8 finish");
      check_main("R8 no data", base, 2, a, 5, 1'b0);
      check_buf("R8 buffer kept", 2, 4, 0, 1'b0);
      wr(1, 32'h6);

      // R10 launch while busy
      fill_buf(1);
      base = nfr;
      wr(0, ctrl(1, 0, 0, 1, 16));
      wr(0, ctrl(3, 0, 0, 1, 1));
      rd(1, d); chk(d[2] == 1'b1 && d[0] == 1'b1, "R10 error while busy", d, 32'h5);
      wait_idle("R10 finish");
      chk(nfr == base + 1, "R10 single frame", 32'(nfr - base), 1);
      check_main("R10 frame intact", base, 1, 24'h0, 16, 1'b1);
      wr(1, 32'h6);

      // R11 count above buffer
      base = nfr;
      wr(0, ctrl(1, 0, 0, 1, 20));
      rd(1, d); chk(d == 32'h4, "R11 error no busy", d, 32'h4);
      repeat (60) @(negedge clk);
      chk(nfr == base && spi_cs_n == 1'b1, "R11 no activity", 32'(nfr - base), 0);
      wr(1, 32'h4);
      rd(1, d); chk(d == 32'h0, "R11 error cleared", d, 32'h0);

      // R4 lock
      wr(2, 32'h1);
      wr(6, 32'h0);
      wr(5, 32'h0);
      wr(4, 32'hFFFF);
      rd(6, d); chk(d == {opc(3), opc(2), opc(1), opc(0)}, "R4 menu frozen", d, {opc(3), opc(2), opc(1), opc(0)});
      rd(5, d); chk(d == 32'hE4E4, "R4 kinds frozen", d, 32'hE4E4);
      rd(4, d); chk(d == 32'h5006, "R4 prefix frozen", d, 32'h5006);
      wr(2, 32'h0);
      rd(2, d); chk(d == 32'h1, "R4 lock sticky", d, 32'h1);
      base = nfr;
      wr(0, ctrl(0, 0, 0, 0, 1));
      wait_idle("R4 finish");
      check_main("R4 locked menu used", base, 0, 24'h0, 1, 1'b0);

      // R12 SCK phase timing
      chk(hi_max - hi_min < 0.01 && hi_min > HALF * 5 - 0.01 && hi_min < HALF * 5 + 0.01,
          "R12 sck half period", 32'(int'(hi_min)), 32'(HALF * 5));

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule